// File: doc/BRIEF.md
# Floating-Point Exception Flag and Trap Unit

This block holds a 32-bit floating-point status word and folds into it the IEEE 754 exception flags that one arithmetic operation reports. Each flag set arrives as a valid/ready transfer. An accepted set replaces the current-exception field. The block then tests that field against the trap-enable field. If any enabled exception is present, it writes the IEEE-exception trap-type code and pulses a trap request for one cycle. Otherwise it ORs the current exceptions into the accrued field. A flag set of all zeros leaves the word alone. Nothing from one transfer carries over into the next.

Software reads the word continuously and can overwrite it through a single-cycle write strobe. A write wins over a flag transfer. While the write strobe is high, `flag_ready` is low, so the producer holds its flags and they are applied in the first cycle after the write. Back-pressure comes only from this rule. The producer must keep `flag_valid` and `flags_in` steady until it sees `flag_ready` high at a clock edge. The block also decodes the two-bit rounding-direction field into a one-hot mode for the arithmetic datapath.

Top module: `fp_exc_unit`

## Requirements
- R1: After reset the status word is all zeros, `trap_req` is low and `flag_ready` is high.
- R2: An accepted transfer with non-zero flags writes them to bits 4:0 of the word, replacing the old contents: invalid at bit 4, overflow at 3, underflow at 2, divide-by-zero at 1, inexact at 0.
- R3: When none of the accepted flags is enabled in the trap-enable field (bits 27:23, same bit order as R2), the flags are ORed into the accrued field (bits 9:5, same order), and all other bits are kept.
- R4: When any accepted flag is also enabled, bits 16:14 become 3'b001, the accrued field is unchanged, and `trap_req` is high in the cycle after the accepting edge, for that one cycle only.
- R5: An accepted transfer with all flags zero changes no bit of the word and raises no trap.
- R6: Each update uses only the flags of its own transfer; flags from an earlier transfer never show up in a later current-exception field.
- R7: With `sr_we` high, the word takes `sr_wdata` at the clock edge and `flag_ready` is low; a held flag transfer is applied at the next edge with `sr_we` low, on top of the written value.
- R8: `rm_onehot` decodes bits 31:30 as 00 to bit 0 (nearest-even), 01 to bit 1 (toward zero), 10 to bit 2 (toward +infinity) and 11 to bit 3 (toward -infinity).
- R9: `trap_req` is low in any cycle that does not follow an accepted transfer whose flags hit an enabled exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_valid | input | 1 | Flag set is present |
| flag_ready | output | 1 | Flag set accepted at this edge when valid |
| flags_in | input | 5 | Exception flags: invalid, overflow, underflow, div-by-zero, inexact (MSB first) |
| sr_we | input | 1 | Software write strobe for the status word |
| sr_wdata | input | 32 | Value to write |
| sr_rdata | output | 32 | Current status word |
| trap_req | output | 1 | One-cycle floating-point exception trap request |
| rm_onehot | output | 4 | Decoded rounding direction |

## Verification
The hardest case to produce is a flag transfer that collides with a software write. The flags must stall while the write lands, and then be applied to the freshly written word rather than to the old one. The bench raises `sr_we` and `flag_valid` together on the same edge. It checks that `flag_ready` is low, and then expects two results in order: first the written word, then that word with the held flags folded in. Two trapping transfers sent back to back check that the trap pulse repeats, and a quiet transfer right after a trap checks that earlier flags do not leak into the current-exception field.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int FLAG_W = 5;
  localparam int SR_W   = 32;
  localparam int RM_W   = 4;

  // Flag order: MSB invalid ... LSB inexact
  typedef struct packed {
    logic nv;
    logic of;
    logic uf;
    logic dz;
    logic nx;
  } fpx_flags_t;

  typedef enum logic [1:0] {
    RD_NEAR = 2'b00,
    RD_ZERO = 2'b01,
    RD_UP   = 2'b10,
    RD_DOWN = 2'b11
  } fpx_rd_e;

  localparam logic [2:0] FTT_IEEE = 3'b001;
endpackage

// File: rtl/fpx_flag_merge.sv
module fpx_flag_merge
  import fpx_pkg::*;
#(
  parameter int W         = SR_W,
  parameter int NF        = FLAG_W,
  parameter int CEXC_LSB  = 0,
  parameter int AEXC_LSB  = 5,
  parameter int TEM_LSB   = 23,
  parameter int FTT_LSB   = 14,
  parameter int FTT_W     = 3
) (
  input  logic [W-1:0]  sr_cur,
  input  fpx_flags_t    flags,
  output logic [W-1:0]  sr_next,
  output logic          trap_hit,
  output logic          any_flag
);
  localparam int CEXC_MSB = CEXC_LSB + NF - 1;
  localparam int AEXC_MSB = AEXC_LSB + NF - 1;
  localparam int FTT_MSB  = FTT_LSB + FTT_W - 1;

  logic [NF-1:0] fvec;
  logic [NF-1:0] hit_bits;
  logic [NF-1:0] acc_bits;

  assign fvec = flags;

  for (genvar i = 0; i < NF; i++) begin : g_bit
    assign hit_bits[i] = fvec[i] & sr_cur[TEM_LSB + i];
    assign acc_bits[i] = fvec[i] | sr_cur[AEXC_LSB + i];
  end

  assign any_flag = |fvec;
  assign trap_hit = |hit_bits;

  always_comb begin
    sr_next = sr_cur;
    if (any_flag) begin
      sr_next[CEXC_MSB:CEXC_LSB] = fvec;
      if (trap_hit) begin
        sr_next[FTT_MSB:FTT_LSB] = FTT_IEEE;
      end else begin
        sr_next[AEXC_MSB:AEXC_LSB] = acc_bits;
      end
    end
  end
endmodule

// File: rtl/fpx_rnd_decode.sv
module fpx_rnd_decode
  import fpx_pkg::*;
(
  input  logic [1:0]      rd_field,
  output logic [RM_W-1:0] rm_onehot
);
  fpx_rd_e rd;
  assign rd = fpx_rd_e'(rd_field);

  always_comb begin
    unique case (rd)
      RD_NEAR: rm_onehot = 4'b0001;
      RD_ZERO: rm_onehot = 4'b0010;
      RD_UP:   rm_onehot = 4'b0100;
      RD_DOWN: rm_onehot = 4'b1000;
      default: rm_onehot = 4'b0010;
    endcase
  end
endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_we,
  input  logic [W-1:0] sw_data,
  input  logic         upd_en,
  input  logic [W-1:0] upd_data,
  input  logic         upd_trap,
  output logic [W-1:0] sr_q,
  output logic         trap_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q   <= '0;
      trap_q <= 1'b0;
    end else begin
      trap_q <= 1'b0;
      if (sw_we) begin
        sr_q <= sw_data;
      end else if (upd_en) begin
        sr_q   <= upd_data;
        trap_q <= upd_trap;
      end
    end
  end
endmodule

// File: rtl/fp_exc_unit.sv
module fp_exc_unit
  import fpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_valid,
  output logic              flag_ready,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic              sr_we,
  input  logic [SR_W-1:0]   sr_wdata,
  output logic [SR_W-1:0]   sr_rdata,
  output logic              trap_req,
  output logic [RM_W-1:0]   rm_onehot
);
  localparam int RD_LSB = 30;

  logic [SR_W-1:0] sr_q;
  logic [SR_W-1:0] sr_next;
  logic            hit;
  logic            any_flag;
  logic            accept;

  assign flag_ready = ~sr_we;
  assign accept     = flag_valid & flag_ready;

  fpx_flag_merge #(.W(SR_W), .NF(FLAG_W)) u_merge (
    .sr_cur   (sr_q),
    .flags    (fpx_flags_t'(flags_in)),
    .sr_next  (sr_next),
    .trap_hit (hit),
    .any_flag (any_flag)
  );

  fpx_status_reg #(.W(SR_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_we    (sr_we),
    .sw_data  (sr_wdata),
    .upd_en   (accept & any_flag),
    .upd_data (sr_next),
    .upd_trap (hit),
    .sr_q     (sr_q),
    .trap_q   (trap_req)
  );

  fpx_rnd_decode u_rnd (
    .rd_field  (sr_q[RD_LSB+1:RD_LSB]),
    .rm_onehot (rm_onehot)
  );

  assign sr_rdata = sr_q;
endmodule

// File: rtl/fpx_exc_checker.sv
module fpx_exc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        flag_valid,
  input logic        flag_ready,
  input logic [4:0]  flags_in,
  input logic        sr_we,
  input logic [31:0] sr_wdata,
  input logic [31:0] sr_rdata,
  input logic        trap_req,
  input logic [3:0]  rm_onehot
);
  assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we |=> sr_rdata == $past(sr_wdata));

  assert_stall_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we |-> !flag_ready);

  assert_trap_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(flag_valid && flag_ready && flags_in != 5'd0));

  assert_trap_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> sr_rdata[16:14] == 3'b001);

  assert_quiet_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_valid && flag_ready && flags_in == 5'd0) |=> ($stable(sr_rdata) && !trap_req));

  assert_cexc_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_valid && flag_ready && flags_in != 5'd0) |=> sr_rdata[4:0] == $past(flags_in));

  assert_rm_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rm_onehot) == 1);
endmodule

bind fp_exc_unit fpx_exc_checker i_chk (.*);

// File: tb/test_fp_exc_unit.sv
module test_fp_exc_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flag_valid = 1'b0;
  logic        flag_ready;
  logic [4:0]  flags_in = '0;
  logic        sr_we = 1'b0;
  logic [31:0] sr_wdata = '0;
  logic [31:0] sr_rdata;
  logic        trap_req;
  logic [3:0]  rm_onehot;

  fp_exc_unit i_fp_exc_unit (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [31:0] sr;
    logic        trap;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          n_run = 0;
  int          n_fail = 0;
  logic [31:0] m = '0;
  bit          done = 0;

  function automatic logic [3:0] rm_of(logic [31:0] s);
    return 4'b0001 << s[31:30];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(logic t, string req);
    exp_t e;
    e.sr = m; e.trap = t; e.req = req;
    sb.push_back(e);
  endtask

  // model from R2..R5
  task automatic apply(logic [4:0] f, output logic t);
    t = 1'b0;
    if (f != 0) begin
      t = |(f & m[27:23]);
      m[4:0] = f;
      if (t) m[16:14] = 3'b001;
      else   m[9:5] = m[9:5] | f;
    end
  endtask

  task automatic send(logic [4:0] f, string req);
    logic t;
    @(negedge clk);
    flag_valid = 1'b1; flags_in = f;
    @(posedge clk); #1;
    flag_valid = 1'b0;
    apply(f, t);
    push(t, req);
  endtask

  task automatic idle(string req);
    @(posedge clk); #1;
    push(1'b0, req);
  endtask

  task automatic sw_write(logic [31:0] w, string req);
    @(negedge clk);
    sr_we = 1'b1; sr_wdata = w;
    @(posedge clk); #1;
    sr_we = 1'b0;
    m = w;
    push(1'b0, req);
  endtask

  // monitor
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk({e.req, " word"}, sr_rdata, e.sr);
      chk({e.req, " trap"}, {31'd0, trap_req}, {31'd0, e.trap});
      chk("R8 rm", {28'd0, rm_onehot}, {28'd0, rm_of(e.sr)});
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic t;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset word", sr_rdata, 32'h0);
    chk("R1 reset trap", {31'd0, trap_req}, 32'd0);
    chk("R1 reset ready", {31'd0, flag_ready}, 32'd1);
    chk("R8 reset rm", {28'd0, rm_onehot}, 32'd1);

    send(5'b00001, "R2 inexact");
    send(5'b10000, "R3 accrue invalid");
    send(5'b00000, "R5 quiet");
    idle("R5 hold");
    sw_write(m | (32'b01000 << 23), "R7 enable overflow");
    send(5'b00001, "R3 masked inexact");
    send(5'b01001, "R4 overflow trap");
    idle("R9 pulse ends");
    send(5'b00010, "R6 fresh flags");
    send(5'b01000, "R4 trap one");
    send(5'b01000, "R4 trap two");
    idle("R9 quiet after");
    send(5'b00100, "R3 underflow");

    // R7 collision: write and flags on same edge
    @(negedge clk);
    sr_we = 1'b1; sr_wdata = 32'h0000_0000 | (32'b00100 << 23);
    flag_valid = 1'b1; flags_in = 5'b00100;
    #1 chk("R7 ready low", {31'd0, flag_ready}, 32'd0);
    @(posedge clk); #1;
    sr_we = 1'b0;
    m = sr_wdata;
    push(1'b0, "R7 write wins");
    @(posedge clk); #1;
    flag_valid = 1'b0;
    apply(5'b00100, t);
    push(t, "R7 held flags applied");
    idle("R9 after collision");

    sw_write(32'h4000_0000, "R8 toward zero");
    sw_write(32'h8000_0000, "R8 plus inf");
    sw_write(32'hC000_0000, "R8 minus inf");
    sw_write(32'h0000_0000, "R8 nearest");

    repeat (3) @(posedge clk);
    while (sb.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule